// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block gathers a vector of interrupt request lines into one interrupt output for a processor. Each request line has its own choice of sensing: it is either edge-sensitive, where it latches a pending flag on the chosen transition and holds it until software clears it, or level-sensitive, where the pending flag tracks whether the line sits at its active level. Each line also has a polarity choice and a disable bit. The combined output is raised while any enabled line is pending.

Software sees four 32-bit registers through a simple word-addressed read/write port: sense-mode select, polarity select, disable mask, and the pending flags. The pending flags are cleared by writing ones. In the default build, lines 0 to 13 are allotted to the buffer manager, the one-shot timer, the SPI controller, the I2C controller, the network PHY, transmit underrun, receive overrun, the pulse-per-second input, UART receive, UART transmit, the serial link, clock status, the periodic timer and a push button. The remaining lines are free.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the sense-mode register reads 0 (all lines level-sensitive), polarity reads all ones (active-high), the mask reads all ones (all lines disabled), pending reads 0 and `irq_out` is 0.
- R2: Word address 0 is the sense-mode register, 1 the polarity register, 2 the mask register and 3 the pending register; data written to addresses 0, 1 and 2 reads back unchanged, and `reg_rdata` carries the addressed value in the cycle after `reg_rd` is sampled high.
- R3: A line whose sense-mode bit is 1 sets its pending bit on a 0-to-1 transition when its polarity bit is 1 and on a 1-to-0 transition when its polarity bit is 0; the bit reads 1 from the clock edge that first samples the new input level.
- R4: An edge-sensitive pending bit stays 1 after the input returns to idle and after a write of 0 to that bit, and becomes 0 when 1 is written to that bit at address 3.
- R5: A line whose sense-mode bit is 0 has a pending bit equal to (input == polarity bit) as sampled at the previous clock edge; writing 1 to it has no lasting effect while the input stays at the active level, and it drops to 0 once the input leaves that level.
- R6: A mask bit of 1 removes that line from `irq_out` while its pending bit is still recorded and readable.
- R7: `irq_out` is the OR of all pending bits whose mask bit is 0, registered, so it changes one clock after the pending bits or mask change.
- R8: If a selected edge and a write of 1 to the same pending bit occur in the same cycle, the pending bit ends up 1.
- R9: In edge-sensitive mode the transition opposite to the one selected does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address (0 mode, 1 polarity, 2 mask, 3 pending) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_req | input | NUM_LINES | Interrupt request lines |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
A wrong internal state shows up at the ports within two cycles: a pending flag that is set, lost or stuck appears in a pending readback one cycle after the read strobe and, for an unmasked line, flips `irq_out` one cycle after the flag itself. A stale edge history register shows up as a missing or spurious pending bit on the very next transition of that line. The bench sweeps every line through all four sense and polarity combinations with only that line enabled, so a fault tied to one bit position or one mode is isolated to the exact line and readback where it appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_MODE = 2'd0,
    REG_POL  = 2'd1,
    REG_MASK = 2'd2,
    REG_PEND = 2'd3
  } irqc_reg_e;

  // Default line allotment
  localparam int LINE_BUFMGR   = 0;
  localparam int LINE_ONESHOT  = 1;
  localparam int LINE_SPI      = 2;
  localparam int LINE_I2C      = 3;
  localparam int LINE_PHY      = 4;
  localparam int LINE_UNDERRUN = 5;
  localparam int LINE_OVERRUN  = 6;
  localparam int LINE_PPS      = 7;
  localparam int LINE_UART_RX  = 8;
  localparam int LINE_UART_TX  = 9;
  localparam int LINE_SERLINK  = 10;
  localparam int LINE_CLKSTAT  = 11;
  localparam int LINE_PERIODIC = 12;
  localparam int LINE_BUTTON   = 13;

endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NUM_LINES-1:0]  mode_edge,
  output logic [NUM_LINES-1:0]  pol_high,
  output logic [NUM_LINES-1:0]  mask_off,
  output logic [NUM_LINES-1:0]  clr_vec
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_edge <= '0;
      pol_high  <= '1;
      mask_off  <= '1;
    end else if (wr_en) begin
      case (addr)
        REG_MODE: mode_edge <= wr_data[NUM_LINES-1:0];
        REG_POL:  pol_high  <= wr_data[NUM_LINES-1:0];
        REG_MASK: mask_off  <= wr_data[NUM_LINES-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    clr_vec = '0;
    if (wr_en && addr == REG_PEND) clr_vec = wr_data[NUM_LINES-1:0];
  end

  AST_RESET_MASKED: assert property (@(posedge clk) rst |=> (mask_off == '1 && mode_edge == '0)); // R1

endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic edge_mode,
  input  logic pol,
  input  logic clr,
  output logic pend
);

  logic req_q;
  logic at_active;
  logic hit_edge;
  logic pend_n;

  always_comb begin
    at_active = (req == pol);
    hit_edge  = at_active && (req_q != pol);
    if (edge_mode) pend_n = hit_edge | (pend & ~clr);
    else           pend_n = at_active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_q <= req;
      pend  <= pend_n;
    end
  end

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && req == pol && req_q != pol) |=> pend); // R3

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && pend && !clr) |=> pend); // R4

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode) |=> (pend == $past(req == pol))); // R5

  AST_NO_WRONG_EDGE: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && !pend && !(req == pol && req_q != pol)) |=> !pend); // R9

endmodule

// File: rtl/irqc_readback.sv
module irqc_readback
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NUM_LINES-1:0]  mode_edge,
  input  logic [NUM_LINES-1:0]  pol_high,
  input  logic [NUM_LINES-1:0]  mask_off,
  input  logic [NUM_LINES-1:0]  pend,
  output logic [DATA_W-1:0]     rd_data
);

  logic [NUM_LINES-1:0] sel_vec;
  logic [DATA_W-1:0]    sel_word;

  always_comb begin
    case (addr)
      REG_MODE: sel_vec = mode_edge;
      REG_POL:  sel_vec = pol_high;
      REG_MASK: sel_vec = mask_off;
      default:  sel_vec = pend;
    endcase
    sel_word = '0;
    sel_word[NUM_LINES-1:0] = sel_vec;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_word;
  end

  AST_RD_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_MASK) |=> (rd_data[NUM_LINES-1:0] == $past(mask_off))); // R2

  AST_RD_PEND: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_PEND) |=> (rd_data[NUM_LINES-1:0] == $past(pend))); // R2

endmodule

// File: rtl/irqc_merge.sv
module irqc_merge #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] mask_off,
  output logic                 irq_out
);

  logic [NUM_LINES-1:0] live;

  always_comb live = pend & ~mask_off;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |live;
  end

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !irq_out); // R7

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mask_off == '1) |=> !irq_out); // R6

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_LINES-1:0]  irq_req,
  output logic                  irq_out
);

  logic [NUM_LINES-1:0] mode_edge;
  logic [NUM_LINES-1:0] pol_high;
  logic [NUM_LINES-1:0] mask_off;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] pend;

  irqc_cfg #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
    .mode_edge(mode_edge), .pol_high(pol_high), .mask_off(mask_off), .clr_vec(clr_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irqc_line u_line (
      .clk(clk), .rst(rst), .req(irq_req[g]), .edge_mode(mode_edge[g]),
      .pol(pol_high[g]), .clr(clr_vec[g]), .pend(pend[g])
    );
  end

  irqc_readback #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .rd_en(reg_rd), .addr(reg_addr),
    .mode_edge(mode_edge), .pol_high(pol_high), .mask_off(mask_off), .pend(pend),
    .rd_data(reg_rdata)
  );

  irqc_merge #(.NUM_LINES(NUM_LINES)) u_merge (
    .clk(clk), .rst(rst), .pend(pend), .mask_off(mask_off), .irq_out(irq_out)
  );

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == REG_PEND && mode_edge[0] && irq_req[0] == pol_high[0]
     && $past(irq_req[0]) != pol_high[0]) |=> pend[0]); // R8

  AST_OUT_IS_OR: assert property (@(posedge clk) disable iff (rst)
    (|(pend & ~mask_off)) |=> irq_out); // R7

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] irq_req;
  logic        irq_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_ctrl #(.NUM_LINES(32), .DATA_W(32)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; irq_req = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(2'd0, v); chk("R1 mode", v, 32'h0);
    rd(2'd1, v); chk("R1 pol", v, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R1 pend", v, 32'h0);

    // R2 register map readback
    foreach (uut.reg_wdata[k]) begin end
    for (int n = 0; n < 4; n++) begin
      logic [31:0] pat;
      pat = 32'hA5C3_5A3C ^ (32'h1111_1111 * n) ^ (32'd1 << (n * 7));
      wr(2'd0, pat);      wr(2'd1, ~pat);     wr(2'd2, pat ^ 32'hFFFF_0000);
      rd(2'd0, v); chk("R2 mode readback", v, pat);
      rd(2'd1, v); chk("R2 pol readback", v, ~pat);
      rd(2'd2, v); chk("R2 mask readback", v, pat ^ 32'hFFFF_0000);
    end
    wr(2'd0, 32'h0); wr(2'd1, 32'hFFFF_FFFF); wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R2 pend after restore", v, 32'h0);

    // Sweep every line through the four mode/polarity combinations
    for (int i = 0; i < 32; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic e, p;
        logic [31:0] bit_i;
        e = m[1]; p = m[0];
        bit_i = 32'd1 << i;
        irq_req = p ? 32'h0 : bit_i;
        wr(2'd0, e ? bit_i : 32'h0);
        wr(2'd1, p ? 32'hFFFF_FFFF : ~bit_i);
        wr(2'd2, ~bit_i);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R3 R5 idle pend", v, 32'h0);
        chk("R7 idle irq_out", {31'd0, irq_out}, 32'd0);

        // drive the active level / selected edge
        irq_req[i] = p;
        @(negedge clk); chk("R7 latency irq_out", {31'd0, irq_out}, 32'd0);
        @(negedge clk); chk("R7 irq_out set", {31'd0, irq_out}, 32'd1);
        rd(2'd3, v); chk(e ? "R3 edge pend" : "R5 level pend", v, bit_i);

        // mask hides the line but pending stays
        wr(2'd2, 32'hFFFF_FFFF);
        @(negedge clk); chk("R6 masked irq_out", {31'd0, irq_out}, 32'd0);
        rd(2'd3, v); chk("R6 pend kept", v, bit_i);
        wr(2'd2, ~bit_i);
        @(negedge clk); chk("R7 unmasked irq_out", {31'd0, irq_out}, 32'd1);

        // writing zeros clears nothing
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R4 zero write", v, bit_i);

        // write-one clear while input held active
        wr(2'd3, bit_i);
        rd(2'd3, v); chk(e ? "R4 edge clear" : "R5 level clear ignored", v, e ? 32'h0 : bit_i);

        // back to idle (opposite edge for edge mode)
        irq_req[i] = ~p;
        @(negedge clk); @(negedge clk);
        rd(2'd3, v); chk(e ? "R9 opposite edge" : "R5 level drop", v, 32'h0);
        chk("R7 irq_out idle", {31'd0, irq_out}, 32'd0);

        if (e) begin
          irq_req[i] = p;
          @(negedge clk);
          irq_req[i] = ~p;
          @(negedge clk); @(negedge clk);
          rd(2'd3, v); chk("R4 sticky after idle", v, bit_i);
          chk("R4 irq_out sticky", {31'd0, irq_out}, 32'd1);
          // clear and new edge in the same cycle
          @(negedge clk);
          reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = bit_i; irq_req[i] = p;
          @(negedge clk);
          reg_wr = 1'b0;
          rd(2'd3, v); chk("R8 edge beats clear", v, bit_i);
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule